// File: doc/BRIEF.md
# Code Privilege Level Controller

This block decides how much a piece of running code is allowed to touch. It looks at where the current instruction came from, derives the highest rights that location may hold, and keeps a stored rights level that is never allowed to exceed that ceiling. Program space is cut into pages by two boundary registers. Pages below the loader base form the system region. Pages from the loader base up to the application base form the loader region. Pages from the application base upward form the application region. Fetches from the boot ROM window may hold full rights. Fetches from RAM hold none.

Software changes the level in one of two ways. A direct level write takes effect only if it stays within the ceiling, and it clears the arming register. The second way is a two-step raise: an arming write, clamped to the ceiling, followed by a commit write. The commit sets the level to the intersection of its data, the armed value and the ceiling. Data accesses to program space are granted or refused from the current level. Any refused write or refused access produces a one-cycle fault pulse and leaves all stored state as it was.

The level is a 4-bit rights mask: bit 3 allows system writes, bit 2 allows system reads, bit 1 allows loader writes and bit 0 allows loader reads. Full rights are 1111b, loader rights 0011b and none 0000b. A "minimum" of two levels is their bitwise AND. A level "exceeds" a limit when it has any bit that the limit lacks.

Top module: `code_priv_ctrl`

## Requirements
- R1: After reset the stored level is 1111b, the arming register is 0000b, both boundary registers hold page 80h and the fault output is low.
- R2: The fetch ceiling depends on where the fetch comes from. A fetch with fetch_ram=1 gets 0000b. Otherwise, a fetch whose page (fetch_ip[15:8]) is 80h or above gets 1111b. Otherwise the page is compared with the boundaries: below the loader base gives 1111b, below the application base gives 0011b, and any other page gives 0000b.
- R3: cur_lvl always equals the stored level ANDed with the ceiling of the current fetch, in the same cycle. At every clock edge with no accepted level change, the stored level is itself ANDed with the ceiling, so returning to a higher region does not restore rights.
- R4: A level write whose data does not exceed the ceiling sets the stored level to the data at the next edge and clears the arming register to 0000b.
- R5: A level write whose data exceeds the ceiling is refused. It raises a fault and does not clear the arming register.
- R6: An arming write stores its data ANDed with the ceiling and never faults.
- R7: A commit write sets the stored level to its data ANDed with the arming register and the ceiling, and leaves the arming register unchanged.
- R8: acc_grant is high in the same cycle as the request when the access is allowed. Allowed accesses are: a read of the system region with cur_lvl bit 2 set, a write of the system region with bit 3 set, a read of the loader region with bit 0 set, a write of the loader region with bit 1 set, and any access to the application region. The region of acc_addr is found from its page and the boundaries only.
- R9: priv_fault goes high for exactly the cycle after a refused level write, a refused boundary write or a refused access. It stays high longer only if a new refusal occurs.
- R10: A boundary write (base_sel 0 = loader base, 1 = application base) is accepted only when cur_lvl bit 3 is set. Otherwise it faults and both boundaries stay unchanged.
- R11: When several register strobes arrive in one cycle, only one is acted on, in this priority: level write, then commit, then arming, then boundary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_ip | input | 16 | Address of the instruction being executed |
| fetch_ram | input | 1 | Current instruction was fetched from RAM |
| lvl_we | input | 1 | Direct level write strobe |
| lvl_wdata | input | 4 | Direct level write data |
| arm_we | input | 1 | Arming write strobe |
| arm_wdata | input | 4 | Arming write data |
| commit_we | input | 1 | Commit write strobe |
| commit_wdata | input | 4 | Commit write data |
| base_we | input | 1 | Boundary register write strobe |
| base_sel | input | 1 | 0 selects the loader base, 1 selects the application base |
| base_wdata | input | 8 | Boundary page value |
| acc_req | input | 1 | Program-space data access request |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 16 | Access address |
| cur_lvl | output | 4 | Effective rights level |
| acc_grant | output | 1 | Access allowed |
| priv_fault | output | 1 | One-cycle privilege fault pulse |

## Verification
Some behaviours are checked by assertions on every cycle. These are that the stored level never holds a bit above the previous ceiling, that the armed value stays within its ceiling, that a refused level or boundary write leaves state untouched, that a granted system write always carries the system-write bit, that RAM fetches always read as zero rights, and that every fault pulse has a refusal behind it. Other behaviours can only be shown by the bench's scenarios, because they are sequences. These are the two-step raise with its arming and commit order, the loss of rights after visiting a lower region and coming back, the effect of moved boundaries, and the strobe priority.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

  localparam int LVL_W = 4;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_FULL = 4'b1111;
  localparam lvl_t LVL_LDR  = 4'b0011;
  localparam lvl_t LVL_NONE = 4'b0000;

  // rights bit positions
  localparam int BIT_SYS_WR = 3;
  localparam int BIT_SYS_RD = 2;
  localparam int BIT_LDR_WR = 1;
  localparam int BIT_LDR_RD = 0;

  typedef enum logic [1:0] {
    RG_SYS = 2'd0,
    RG_LDR = 2'd1,
    RG_APP = 2'd2
  } region_t;

  // lowest common rights of two levels
  function automatic lvl_t lvl_min(input lvl_t a, input lvl_t b);
    return a & b;
  endfunction

  // true when req carries a right that lim lacks
  function automatic logic lvl_over(input lvl_t req, input lvl_t lim);
    return |(req & ~lim);
  endfunction

  function automatic lvl_t region_ceiling(input region_t rg);
    case (rg)
      RG_SYS:  return LVL_FULL;
      RG_LDR:  return LVL_LDR;
      default: return LVL_NONE;
    endcase
  endfunction

  function automatic logic access_ok(input region_t rg, input logic wr, input lvl_t lvl);
    case (rg)
      RG_SYS:  return wr ? lvl[BIT_SYS_WR] : lvl[BIT_SYS_RD];
      RG_LDR:  return wr ? lvl[BIT_LDR_WR] : lvl[BIT_LDR_RD];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/cpl_region_decode.sv
module cpl_region_decode
  import cpl_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] ldr_base,
  input  logic [PAGE_W-1:0] app_base,
  output region_t           region
);

  logic below_ldr;
  logic below_app;

  assign below_ldr = page < ldr_base;
  assign below_app = page < app_base;

  always_comb begin
    if (below_ldr)      region = RG_SYS;
    else if (below_app) region = RG_LDR;
    else                region = RG_APP;
  end

endmodule

// File: rtl/cpl_fetch_limit.sv
module cpl_fetch_limit
  import cpl_pkg::*;
#(
  parameter int            IP_W     = 16,
  parameter int            PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] ROM_PAGE = 8'h80
) (
  input  logic [IP_W-1:0]   ip,
  input  logic              from_ram,
  input  logic [PAGE_W-1:0] ldr_base,
  input  logic [PAGE_W-1:0] app_base,
  output lvl_t              ceiling
);

  localparam int OFF_W = IP_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic              in_rom;
  region_t           rg;

  assign page   = ip[IP_W-1:OFF_W];
  assign in_rom = page >= ROM_PAGE;

  cpl_region_decode #(.PAGE_W(PAGE_W)) u_fetch_rg (
    .page     (page),
    .ldr_base (ldr_base),
    .app_base (app_base),
    .region   (rg)
  );

  always_comb begin
    if (from_ram)    ceiling = LVL_NONE;
    else if (in_rom) ceiling = LVL_FULL;
    else             ceiling = region_ceiling(rg);
  end

endmodule

// File: rtl/cpl_access_gate.sv
module cpl_access_gate
  import cpl_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [IP_W-1:0]   addr,
  input  logic [PAGE_W-1:0] ldr_base,
  input  logic [PAGE_W-1:0] app_base,
  input  lvl_t              lvl,
  output logic              grant,
  output logic              deny
);

  localparam int OFF_W = IP_W - PAGE_W;

  region_t rg;
  logic    ok;

  cpl_region_decode #(.PAGE_W(PAGE_W)) u_acc_rg (
    .page     (addr[IP_W-1:OFF_W]),
    .ldr_base (ldr_base),
    .app_base (app_base),
    .region   (rg)
  );

  assign ok    = access_ok(rg, wr, lvl);
  assign grant = req && ok;
  assign deny  = req && !ok;

  AST_SYS_WR_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && wr && rg == RG_SYS) |-> lvl[BIT_SYS_WR]); // R8
  AST_LDR_RD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !wr && rg == RG_LDR) |-> lvl[BIT_LDR_RD]); // R8

endmodule

// File: rtl/cpl_state.sv
module cpl_state
  import cpl_pkg::*;
#(
  parameter int                PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] BASE_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lvl_t              ceiling,
  input  lvl_t              cur_lvl,
  input  logic              lvl_we,
  input  lvl_t              lvl_wdata,
  input  logic              arm_we,
  input  lvl_t              arm_wdata,
  input  logic              commit_we,
  input  lvl_t              commit_wdata,
  input  logic              base_we,
  input  logic              base_sel,
  input  logic [PAGE_W-1:0] base_wdata,
  input  logic              acc_deny,
  output lvl_t              lvl_q,
  output logic [PAGE_W-1:0] ldr_q,
  output logic [PAGE_W-1:0] app_q,
  output logic              fault_q,
  output logic              lvl_deny,
  output logic              base_deny
);

  lvl_t              arm_q;
  lvl_t              lvl_n, arm_n;
  logic [PAGE_W-1:0] ldr_n, app_n;

  // one strobe wins per cycle
  logic win_lvl, win_commit, win_arm, win_base;
  assign win_lvl    = lvl_we;
  assign win_commit = !lvl_we && commit_we;
  assign win_arm    = !lvl_we && !commit_we && arm_we;
  assign win_base   = !lvl_we && !commit_we && !arm_we && base_we;

  assign lvl_deny  = win_lvl  && lvl_over(lvl_wdata, ceiling);
  assign base_deny = win_base && !cur_lvl[BIT_SYS_WR];

  always_comb begin
    lvl_n = lvl_min(lvl_q, ceiling);
    arm_n = arm_q;
    ldr_n = ldr_q;
    app_n = app_q;
    if (win_lvl && !lvl_deny) begin
      lvl_n = lvl_wdata;
      arm_n = LVL_NONE;
    end else if (win_commit) begin
      lvl_n = lvl_min(lvl_min(commit_wdata, arm_q), ceiling);
    end else if (win_arm) begin
      arm_n = lvl_min(arm_wdata, ceiling);
    end else if (win_base && !base_deny) begin
      if (base_sel) app_n = base_wdata;
      else          ldr_n = base_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_FULL;
      arm_q   <= LVL_NONE;
      ldr_q   <= BASE_RST;
      app_q   <= BASE_RST;
      fault_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_n;
      arm_q   <= arm_n;
      ldr_q   <= ldr_n;
      app_q   <= app_n;
      fault_q <= lvl_deny || base_deny || acc_deny;
    end
  end

  AST_STORED_UNDER_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !lvl_over(lvl_q, $past(ceiling))); // R3
  AST_ARM_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    win_arm |=> !lvl_over(arm_q, $past(ceiling))); // R6
  AST_REFUSED_LVL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_deny |=> (lvl_q == $past(lvl_q & ceiling)) && $stable(arm_q)); // R5
  AST_REFUSED_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    base_deny |=> $stable(ldr_q) && $stable(app_q)); // R10
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $past(lvl_deny || base_deny || acc_deny)); // R9
  AST_COMMIT_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    win_commit |=> $stable(arm_q)); // R7

endmodule

// File: rtl/code_priv_ctrl.sv
module code_priv_ctrl
  import cpl_pkg::*;
#(
  parameter int                IP_W     = 16,
  parameter int                PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] BASE_RST = 8'h80,
  parameter logic [PAGE_W-1:0] ROM_PAGE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IP_W-1:0]   fetch_ip,
  input  logic              fetch_ram,
  input  logic              lvl_we,
  input  logic [3:0]        lvl_wdata,
  input  logic              arm_we,
  input  logic [3:0]        arm_wdata,
  input  logic              commit_we,
  input  logic [3:0]        commit_wdata,
  input  logic              base_we,
  input  logic              base_sel,
  input  logic [PAGE_W-1:0] base_wdata,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [IP_W-1:0]   acc_addr,
  output logic [3:0]        cur_lvl,
  output logic              acc_grant,
  output logic              priv_fault
);

  lvl_t              ceiling;
  lvl_t              lvl_q;
  logic [PAGE_W-1:0] ldr_q, app_q;
  logic              acc_deny, lvl_deny, base_deny;

  cpl_fetch_limit #(
    .IP_W(IP_W), .PAGE_W(PAGE_W), .ROM_PAGE(ROM_PAGE)
  ) u_limit (
    .ip       (fetch_ip),
    .from_ram (fetch_ram),
    .ldr_base (ldr_q),
    .app_base (app_q),
    .ceiling  (ceiling)
  );

  assign cur_lvl = lvl_min(lvl_q, ceiling);

  cpl_access_gate #(.IP_W(IP_W), .PAGE_W(PAGE_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (acc_req),
    .wr       (acc_we),
    .addr     (acc_addr),
    .ldr_base (ldr_q),
    .app_base (app_q),
    .lvl      (cur_lvl),
    .grant    (acc_grant),
    .deny     (acc_deny)
  );

  cpl_state #(.PAGE_W(PAGE_W), .BASE_RST(BASE_RST)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .ceiling      (ceiling),
    .cur_lvl      (cur_lvl),
    .lvl_we       (lvl_we),
    .lvl_wdata    (lvl_wdata),
    .arm_we       (arm_we),
    .arm_wdata    (arm_wdata),
    .commit_we    (commit_we),
    .commit_wdata (commit_wdata),
    .base_we      (base_we),
    .base_sel     (base_sel),
    .base_wdata   (base_wdata),
    .acc_deny     (acc_deny),
    .lvl_q        (lvl_q),
    .ldr_q        (ldr_q),
    .app_q        (app_q),
    .fault_q      (priv_fault),
    .lvl_deny     (lvl_deny),
    .base_deny    (base_deny)
  );

  AST_RAM_FETCH_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ram |-> cur_lvl == LVL_NONE); // R2
  AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> !acc_grant); // R8

endmodule

// File: tb/sim_code_priv_ctrl.sv
`timescale 1ns/1ps
module sim_code_priv_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fetch_ip = '0;
  logic        fetch_ram = 1'b0;
  logic        lvl_we = 1'b0, arm_we = 1'b0, commit_we = 1'b0, base_we = 1'b0;
  logic [3:0]  lvl_wdata = '0, arm_wdata = '0, commit_wdata = '0;
  logic        base_sel = 1'b0;
  logic [7:0]  base_wdata = '0;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [3:0]  cur_lvl;
  logic        acc_grant, priv_fault;

  always #5 clk = ~clk;

  code_priv_ctrl u0 (.*);

  typedef struct {
    string      tag;
    logic [3:0] lvl;
    logic       grant;
    logic       fault;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench-side model state
  logic [3:0] m_lvl, m_arm;
  logic [7:0] m_ldr, m_app;
  logic       m_fault;

  function automatic logic [3:0] ceil_of(logic [15:0] ip, logic ram);
    int pg;
    pg = int'(ip >> 8);
    if (ram) return 4'h0;
    if (pg >= 128) return 4'hF;
    if (pg < int'(m_ldr)) return 4'hF;
    if (pg < int'(m_app)) return 4'h3;
    return 4'h0;
  endfunction

  function automatic logic allowed(logic [15:0] a, logic w, logic [3:0] l);
    int pg;
    pg = int'(a >> 8);
    if (pg < int'(m_ldr)) return w ? l[3] : l[2];
    if (pg < int'(m_app)) return w ? l[1] : l[0];
    return 1'b1;
  endfunction

  task automatic step(string tag, logic [15:0] ip, logic ram,
                      logic lw = 0, logic [3:0] ld = 0,
                      logic aw = 0, logic [3:0] ad = 0,
                      logic cw = 0, logic [3:0] cd = 0,
                      logic bw = 0, logic bs = 0, logic [7:0] bd = 0,
                      logic rq = 0, logic rw = 0, logic [15:0] ra = 0);
    exp_t       e;
    logic [3:0] c, eff, nl, na;
    logic [7:0] nldr, napp;
    logic       deny_acc, deny_reg;
    @(negedge clk);
    #1;
    fetch_ip = ip; fetch_ram = ram;
    lvl_we = lw; lvl_wdata = ld; arm_we = aw; arm_wdata = ad;
    commit_we = cw; commit_wdata = cd; base_we = bw; base_sel = bs; base_wdata = bd;
    acc_req = rq; acc_we = rw; acc_addr = ra;
    c   = ceil_of(ip, ram);
    eff = m_lvl & c;
    deny_acc = rq && !allowed(ra, rw, eff);
    e.tag = tag; e.lvl = eff; e.grant = rq && !deny_acc; e.fault = m_fault;
    q.push_back(e);
    nl = eff; na = m_arm; nldr = m_ldr; napp = m_app; deny_reg = 0;
    if (lw) begin
      if ((ld & ~c) != 0) deny_reg = 1;
      else begin nl = ld; na = 4'h0; end
    end else if (cw) begin
      nl = cd & m_arm & c;
    end else if (aw) begin
      na = ad & c;
    end else if (bw) begin
      if (!eff[3]) deny_reg = 1;
      else if (bs) napp = bd;
      else nldr = bd;
    end
    m_lvl = nl; m_arm = na; m_ldr = nldr; m_app = napp;
    m_fault = deny_reg || deny_acc;
  endtask

  // monitor: compare queued expectations just before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (cur_lvl !== e.lvl || acc_grant !== e.grant || priv_fault !== e.fault) begin
          n_fail++;
          $display("FAIL %s: lvl=%h grant=%b fault=%b expected lvl=%h grant=%b fault=%b",
                   e.tag, cur_lvl, acc_grant, priv_fault, e.lvl, e.grant, e.fault);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_lvl = 4'hF; m_arm = 4'h0; m_ldr = 8'h80; m_app = 8'h80; m_fault = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 region ceilings
    step("R1 reset level", 16'h0100, 0);
    step("R1 reset base 80h", 16'h7F00, 0, .rq(1), .rw(1), .ra(16'h7F10));
    step("R2 rom window", 16'h8123, 0);
    step("R2 ram fetch", 16'h0000, 1);
    step("R2 back in system", 16'h0000, 0);
    // R10 boundaries accepted at full rights
    step("R10 set loader base", 16'h0000, 0, .bw(1), .bs(0), .bd(8'h20));
    step("R10 set app base", 16'h0000, 0, .bw(1), .bs(1), .bd(8'h40));
    // R2 and R3 loader and app regions
    step("R2 loader region ceiling", 16'h2000, 0);
    step("R3 app clamp", 16'h4000, 0);
    step("R3 return keeps loss", 16'h0000, 0);
    // R5 refused raise from app, R9 pulse
    step("R5 refused level write", 16'h4400, 0, .lw(1), .ld(4'hF));
    step("R9 fault pulse", 16'h4400, 0);
    step("R9 fault ends", 16'h4400, 0);
    step("R10 refused base write", 16'h4400, 0, .bw(1), .bs(0), .bd(8'h00));
    step("R10 base unchanged", 16'h1F00, 0);
    step("R8 refused sys read", 16'h1F00, 0, .rq(1), .rw(0), .ra(16'h0010));
    step("R9 access fault", 16'h1F00, 0, .rq(1), .rw(0), .ra(16'h5000));
    // R4 direct raise in system region
    step("R4 level write full", 16'h0000, 0, .lw(1), .ld(4'hF));
    step("R8 sys write ok", 16'h0000, 0, .rq(1), .rw(1), .ra(16'h1000));
    step("R8 loader write ok", 16'h0000, 0, .rq(1), .rw(1), .ra(16'h3000));
    // R6 R7 armed raise
    step("R4 drop to none", 16'h0000, 0, .lw(1), .ld(4'h0));
    step("R6 arm from loader clamps", 16'h2000, 0, .aw(1), .ad(4'hF));
    step("R7 commit full", 16'h0000, 0, .cw(1), .cd(4'hF));
    step("R7 commit limited by arm", 16'h0000, 0);
    step("R6 arm in system", 16'h0000, 0, .aw(1), .ad(4'hF));
    step("R7 commit full again", 16'h0000, 0, .cw(1), .cd(4'hF));
    step("R7 result full", 16'h0000, 0);
    step("R4 write clears arm", 16'h0000, 0, .lw(1), .ld(4'h3));
    step("R4 commit after clear", 16'h0000, 0, .cw(1), .cd(4'hF));
    step("R4 commit gave none", 16'h0000, 0, .rq(1), .rw(0), .ra(16'h2100));
    // R11 priority
    step("R11 setup arm", 16'h0000, 0, .aw(1), .ad(4'hF));
    step("R11 level beats commit", 16'h0000, 0, .lw(1), .ld(4'h7), .cw(1), .cd(4'hF));
    step("R11 result", 16'h0000, 0, .cw(1), .cd(4'hF), .aw(1), .ad(4'h0));
    step("R11 commit beat arm", 16'h0000, 0, .cw(1), .cd(4'hF), .bw(1), .bs(0), .bd(8'h00));
    step("R11 base skipped", 16'h1000, 0);
    step("R3 ram then app", 16'h0000, 1);
    step("R3 after ram", 16'h0000, 0);
    step("R9 idle", 16'h0000, 0);
    @(negedge clk);
    #5;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule